// File: doc/BRIEF.md
# Serial Register-Access Target with Buffered Update

This block is a four-wire serial target: chip select, serial clock, and separate data-in and data-out lines. It gives an external host read and write access to a small bank of byte registers. The host lowers chip select and shifts in a 16-bit instruction, most significant bit first. The instruction gives the direction, a length code and a 13-bit starting address. Data bytes follow the instruction. After each byte the address steps down by one. A fixed-length transfer ignores any bytes beyond its count. A streaming transfer continues until chip select goes high.

Writes go only into buffered (shadow) registers. The active registers, which drive the block's outputs, keep their values until the host writes a byte with bit 0 set to the update address 0x5A. That write copies every shadow register into its active register in one cycle and raises a one-cycle update strobe. Reads return the active value of the addressed register.

The block runs on its own system clock. The serial pins are synchronised into that clock domain and their edges are detected there. The serial clock must therefore be several times slower than the system clock. The serial clock idles low: data in is sampled on its rising edge and data out changes on its falling edge.

Top module: `spi_regs_target`

## Requirements
- R1: After reset, active register 0 holds 0x10, every other active register holds 0x00, data out is 0 and the update strobe is 0.
- R2: The instruction is 16 bits, most significant bit first. Bit 15 set to 1 means read and 0 means write. Bits 14:13 are the length code. Bits 12:0 are the start address.
- R3: A write to an implemented address (0 to REG_COUNT-1) changes only its shadow register. The active registers and the values read back stay the same until an update.
- R4: Writing a byte with bit 0 set to address 0x5A copies all shadow registers into the active registers together and pulses the update strobe for one cycle. A byte with bit 0 clear has no effect. Address 0x5A reads as 0x00.
- R5: Length codes 00, 01 and 10 transfer one, two and three bytes. Further bytes in the same transaction are not written, and on a read they return 0 on data out.
- R6: Length code 11 streams bytes until chip select goes high, with no limit on the count.
- R7: The address decreases by one after each data byte, in both fixed-length and streaming modes, and wraps from 0x0000 to 0x1FFF.
- R8: If chip select rises in the middle of a byte, that byte is discarded and not written. The next transaction starts with a new instruction.
- R9: Data out is 0 outside the data phase of a read. Within that phase it changes only on a falling edge of the serial clock and carries each byte most significant bit first.
- R10: A read returns the active value of an implemented address. Unimplemented addresses read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| active_regs | output | REG_COUNT*8 | Active register values, register i in bits [8i+7:8i] |
| upd_strobe | output | 1 | One-cycle pulse in the cycle the active registers take the shadow values |

## Verification
The bench uses the default parameters: eight registers, two synchroniser stages and update address 0x5A. With eight registers, a stream that starts at address 1 or 2 passes address 0 and wraps to 0x1FFF within a few bytes. The random address pool also includes the unimplemented addresses 8, 9 and 0x5A. Both the wrap and the reads of zero from unimplemented addresses are therefore exercised. The serial clock runs at one sixteenth of the system clock, which covers the synchroniser latency with margin. Directed transactions cover an abort in the middle of a byte, bytes beyond the fixed length, and update bytes with bit 0 set and with bit 0 clear.

// File: rtl/spi_regs_pkg.sv
// Package: shared types and constants for the serial register target.
// Assumes the instruction layout {dir, len[1:0], addr[12:0]}.
package spi_regs_pkg;
    localparam int ADDR_W = 13;
    localparam logic [1:0] LEN_STREAM = 2'b11;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;
endpackage

// File: rtl/spi_edge_sync.sv
// Module: brings cs_n, sck and mosi into the clk domain through STAGES
// flops each, then detects the serial clock edges. Assumes that sck is
// much slower than clk and that STAGES >= 2.
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_p;
    logic [TOP:0] sck_p;
    logic [TOP:0] mo_p;
    logic         sck_d;

    // Synchroniser chains plus a delayed copy of sck for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p  <= '1;
            sck_p <= '0;
            mo_p  <= '0;
            sck_d <= 1'b0;
        end else begin
            cs_p  <= {cs_p[TOP-1:0], cs_n};
            sck_p <= {sck_p[TOP-1:0], sck};
            mo_p  <= {mo_p[TOP-1:0], mosi};
            sck_d <= sck_p[TOP];
        end
    end

    assign cs_act   = !cs_p[TOP];
    assign sck_rise = sck_p[TOP] & !sck_d;
    assign sck_fall = !sck_p[TOP] & sck_d;
    assign mosi_s   = mo_p[TOP];
endmodule

// File: rtl/spi_frame_ctrl.sv
// Module: frames the serial stream. It takes in the 16-bit instruction,
// counts the data bytes, steps the address down, issues register writes
// and shifts read data out. Assumes synchronised inputs with single-cycle
// edge pulses.
module spi_frame_ctrl
    import spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              miso
);
    phase_t            phase;
    logic [3:0]        bit_cnt;
    logic [15:0]       shreg;
    logic [15:0]       sh_next;
    logic [ADDR_W-1:0] cur_addr;
    logic              is_rd;
    logic [1:0]        len_code;
    logic [1:0]        bytes_done;
    logic [7:0]        tx_sh;
    logic              miso_q;

    // Next value of the shift register and the address for the read prefetch.
    always_comb begin
        sh_next = {shreg[14:0], mosi_s};
        rd_addr = (phase == PH_INSTR) ? sh_next[ADDR_W-1:0] : cur_addr - 13'd1;
    end

    // Transaction sequencer: decodes the instruction, counts bytes, drives data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_INSTR;
            bit_cnt    <= '0;
            shreg      <= '0;
            cur_addr   <= '0;
            is_rd      <= 1'b0;
            len_code   <= '0;
            bytes_done <= '0;
            tx_sh      <= '0;
            miso_q     <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else if (!cs_act) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            miso_q  <= 1'b0;
            wr_en   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (sck_rise) begin
                case (phase)
                    PH_INSTR: begin
                        shreg <= sh_next;
                        if (bit_cnt == 4'd15) begin
                            is_rd      <= sh_next[15];
                            len_code   <= sh_next[14:13];
                            cur_addr   <= sh_next[ADDR_W-1:0];
                            bytes_done <= '0;
                            tx_sh      <= rd_data;
                            bit_cnt    <= '0;
                            phase      <= PH_DATA;
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    PH_DATA: begin
                        shreg <= sh_next;
                        if (bit_cnt == 4'd7) begin
                            wr_en      <= !is_rd;
                            wr_addr    <= cur_addr;
                            wr_data    <= sh_next[7:0];
                            cur_addr   <= cur_addr - 13'd1;
                            bytes_done <= bytes_done + 2'd1;
                            tx_sh      <= rd_data;
                            bit_cnt    <= '0;
                            if (len_code != LEN_STREAM && bytes_done == len_code)
                                phase <= PH_DONE;
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
            if (sck_fall) begin
                if (phase == PH_DATA && is_rd) begin
                    miso_q <= tx_sh[7];
                    tx_sh  <= {tx_sh[6:0], 1'b0};
                end else begin
                    miso_q <= 1'b0;
                end
            end
        end
    end

    assign miso = miso_q;

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && sck_rise && phase == PH_DATA && bit_cnt == 4'd7)
        |=> (cur_addr == $past(cur_addr) - 13'd1));

    p_miso_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_q);

    p_miso_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sck_fall) |=> $stable(miso_q));

    p_wr_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !is_rd);

    p_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_INSTR) |-> (bit_cnt < 4'd8));
endmodule

// File: rtl/spi_reg_bank.sv
// Module: pairs of shadow and active byte registers. Writes land in the
// shadow registers. A write of bit 0 = 1 to the update address copies all
// shadow registers to the active ones at once. Assumes REG_COUNT <= UPD_ADDR.
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter int          REG_COUNT = 8,
    parameter logic [7:0]  CFG_RESET = 8'h10,
    parameter logic [12:0] UPD_ADDR  = 13'h05A
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_data,
    output logic [REG_COUNT*8-1:0] active_regs,
    output logic                   upd_strobe
);
    localparam int W = REG_COUNT * 8;

    logic [W-1:0]         shadow_q;
    logic [W-1:0]         active_q;
    logic [REG_COUNT-1:0] rd_hit;
    logic [REG_COUNT-1:0] wr_hit;
    logic                 upd_fire;

    // Per-register address decode for the read and write ports.
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_dec
        assign rd_hit[i] = (rd_addr == ADDR_W'(i));
        assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    assign upd_fire = wr_en && (wr_addr == UPD_ADDR) && wr_data[0];

    // Read mux: active value of the hit register, 0 when no register is hit.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < REG_COUNT; i++)
            if (rd_hit[i]) rd_data = active_q[i*8 +: 8];
    end

    // Shadow writes, the update copy and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q   <= {{(W-8){1'b0}}, CFG_RESET};
            active_q   <= {{(W-8){1'b0}}, CFG_RESET};
            upd_strobe <= 1'b0;
        end else begin
            upd_strobe <= upd_fire;
            for (int i = 0; i < REG_COUNT; i++)
                if (wr_hit[i]) shadow_q[i*8 +: 8] <= wr_data;
            if (upd_fire) active_q <= shadow_q;
        end
    end

    assign active_regs = active_q;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(active_q));

    p_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> (active_q == $past(shadow_q)));

    p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> upd_strobe);

    p_unimp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(REG_COUNT)) |=> $stable(shadow_q));
endmodule

// File: rtl/spi_regs_target.sv
// Module: top of the serial register target. It connects the pin
// synchroniser, the frame controller and the register bank. Assumes that
// sck runs at well under 1/8 of clk.
module spi_regs_target
    import spi_regs_pkg::*;
#(
    parameter int          REG_COUNT   = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CFG_RESET   = 8'h10,
    parameter logic [12:0] UPD_ADDR    = 13'h05A
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sck,
    input  logic                   mosi,
    output logic                   miso,
    output logic [REG_COUNT*8-1:0] active_regs,
    output logic                   upd_strobe
);
    logic              cs_act;
    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_s;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    spi_frame_ctrl u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .miso(miso)
    );

    spi_reg_bank #(.REG_COUNT(REG_COUNT), .CFG_RESET(CFG_RESET), .UPD_ADDR(UPD_ADDR)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .active_regs(active_regs),
        .upd_strobe(upd_strobe)
    );
endmodule

// File: tb/tb_spi_regs_target.sv
module tb_spi_regs_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;
    logic [NREG*8-1:0] active_regs;
    logic upd_strobe;

    int errors = 0;
    int nchecks = 0;
    int upd_seen = 0;
    int upd_exp = 0;
    logic [7:0] m_shadow [NREG];
    logic [7:0] m_active [NREG];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regs_target dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .active_regs(active_regs), .upd_strobe(upd_strobe)
    );

    always @(negedge clk) if (rst_n && upd_strobe) upd_seen++;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_active[i];
        return v;
    endfunction

    task automatic spi_bit(input logic b, output logic r);
        @(negedge clk);
        mosi = b;
        repeat (HALF-1) @(negedge clk);
        r = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    // One transaction; abort_bits >= 0 raises chip select after that many data bits.
    task automatic xfer(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                        input int nbytes, input int abort_bits, input string tag);
        logic [15:0] ins;
        logic r;
        logic ibad;
        int total;
        int complete;
        int lim;
        logic [12:0] a;
        ins = {rd, len, addr};
        ibad = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 15; i >= 0; i--) begin
            spi_bit(ins[i], r);
            if (r) ibad = 1'b1;
        end
        check(!ibad, "R9 miso during instruction", ibad, 0);
        total = (abort_bits >= 0) ? abort_bits : nbytes * 8;
        for (int k = 0; k < total; k++) begin
            spi_bit(wbuf[k/8][7 - (k%8)], r);
            rbuf[k/8][7 - (k%8)] = r;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4*HALF) @(negedge clk);
        complete = total / 8;
        lim = (len == 2'b11) ? complete : ((complete < len + 1) ? complete : len + 1);
        for (int i = 0; i < complete; i++) begin
            a = addr - 13'(i);
            if (rd) begin
                if (i < lim)
                    check(rbuf[i] == ((a < NREG) ? m_active[a] : 8'h00), tag, rbuf[i],
                          (a < NREG) ? m_active[a] : 8'h00);
                else
                    check(rbuf[i] == 8'h00, "R5 read beyond length", rbuf[i], 0);
            end else begin
                check(rbuf[i] == 8'h00, "R9 miso during write", rbuf[i], 0);
                if (i < lim) begin
                    if (a < NREG) m_shadow[a] = wbuf[i];
                    else if (a == 13'h05A && wbuf[i][0]) begin
                        for (int j = 0; j < NREG; j++) m_active[j] = m_shadow[j];
                        upd_exp++;
                    end
                end
            end
        end
        check(active_regs == model_flat(), "R3 active registers", active_regs, model_flat());
        check(upd_seen == upd_exp, "R4 update strobe count", upd_seen, upd_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        nchecks++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, nchecks);
        $finish;
    end

    initial begin
        logic rd;
        logic [1:0] len;
        logic [12:0] addr;
        int nb;
        int pick;
        for (int i = 0; i < NREG; i++) begin
            m_shadow[i] = (i == 0) ? 8'h10 : 8'h00;
            m_active[i] = m_shadow[i];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(active_regs == model_flat(), "R1 reset active", active_regs, model_flat());
        check(miso == 1'b0, "R1 reset miso", miso, 0);
        check(upd_strobe == 1'b0, "R1 reset strobe", upd_strobe, 0);
        xfer(1'b1, 2'b00, 13'h0000, 1, -1, "R1 read config reset 0x10");

        // R2/R3: two-byte write into shadows, active unchanged
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
        xfer(1'b0, 2'b01, 13'h0003, 2, -1, "R3");
        xfer(1'b1, 2'b01, 13'h0003, 2, -1, "R3 read still active values");
        // R4: update byte with bit 0 clear does nothing, then set
        wbuf[0] = 8'hFE;
        xfer(1'b0, 2'b00, 13'h005A, 1, -1, "R4");
        wbuf[0] = 8'h01;
        xfer(1'b0, 2'b00, 13'h005A, 1, -1, "R4");
        check(active_regs[3*8 +: 8] == 8'hA1, "R4 copied reg3", active_regs[3*8 +: 8], 8'hA1);
        xfer(1'b1, 2'b00, 13'h005A, 1, -1, "R4 update address reads 0");
        xfer(1'b1, 2'b01, 13'h0003, 2, -1, "R2 R7 read two bytes downward");

        // R5: one-byte length with a second byte clocked
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        xfer(1'b0, 2'b00, 13'h0005, 2, -1, "R5");
        wbuf[0] = 8'h01;
        xfer(1'b0, 2'b00, 13'h005A, 1, -1, "R5");
        check(active_regs[4*8 +: 8] == 8'h00, "R5 extra byte not written", active_regs[4*8 +: 8], 0);
        xfer(1'b1, 2'b01, 13'h0005, 4, -1, "R5 read two then zeros");

        // R6/R7: stream write of five bytes from 7 downward, stream read with wrap
        for (int i = 0; i < 5; i++) wbuf[i] = 8'h30 + 8'(i);
        xfer(1'b0, 2'b11, 13'h0007, 5, -1, "R6");
        wbuf[0] = 8'h01;
        xfer(1'b0, 2'b00, 13'h005A, 1, -1, "R6");
        check(active_regs[3*8 +: 8] == 8'h34, "R6 fifth stream byte", active_regs[3*8 +: 8], 8'h34);
        xfer(1'b1, 2'b11, 13'h0007, 6, -1, "R6 stream read");
        xfer(1'b1, 2'b11, 13'h0001, 4, -1, "R7 wrap past zero");

        // R8: abort mid byte, then a fresh transaction
        wbuf[0] = 8'hFF;
        xfer(1'b0, 2'b00, 13'h0001, 1, 5, "R8");
        wbuf[0] = 8'h01;
        xfer(1'b0, 2'b00, 13'h005A, 1, -1, "R8");
        check(active_regs[1*8 +: 8] == m_active[1], "R8 aborted byte dropped",
              active_regs[1*8 +: 8], m_active[1]);
        wbuf[0] = 8'h9C;
        xfer(1'b0, 2'b00, 13'h0001, 1, -1, "R8 fresh after abort");
        wbuf[0] = 8'h01;
        xfer(1'b0, 2'b00, 13'h005A, 1, -1, "R8");
        check(active_regs[1*8 +: 8] == 8'h9C, "R8 next transaction works", active_regs[1*8 +: 8], 8'h9C);

        // R10: unimplemented address
        wbuf[0] = 8'h77;
        xfer(1'b0, 2'b00, 13'h0020, 1, -1, "R10");
        xfer(1'b1, 2'b00, 13'h0020, 1, -1, "R10 unimplemented reads 0");

        // Random mix
        void'($urandom(32'd20240611));
        for (int t = 0; t < 40; t++) begin
            rd = 1'($urandom % 2);
            len = 2'($urandom % 4);
            pick = int'($urandom % 6);
            if (pick < 4) addr = 13'($urandom % 10);
            else if (pick == 4) addr = 13'h005A;
            else addr = 13'($urandom);
            nb = 1 + int'($urandom % 4);
            for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
            xfer(rd, len, addr, nb, -1, "R10 random read");
        end

        $display("Result: errors=%0d of %0d checks", errors, nchecks);
        $finish;
    end
endmodule